// File: doc/BRIEF.md
# Read-Port Block-Entry Sequencer

This block steers the read side of a large sequential field memory. Every rising edge of the read clock samples three controls: a reset request, a read enable and an output enable. Most of the time the block behaves as a FIFO read port. Each enabled edge presents the current read pointer to the storage array with a strobe, and then moves the pointer on. The registered output-enable level follows the sampled output-enable input, so the data pins can be put into high impedance without stopping the pointer.

A rising reset request normally returns the pointer to zero. The block can also enter a random-block mode. It does so only when the first four edges of the reset carry a fixed pattern of read-enable and output-enable levels. In that mode the output-enable pin stops gating the outputs and serves as a serial address line, carrying the block number most significant bit first. The data pins stay in high impedance while the number is received and while the storage array's read latency runs. Reading then resumes at the first word of the chosen block. A block number that is out of range locks the port until the next reset. A reset request that arrives while the sequence is running is refused and flagged.

All sizes are parameters. The defaults are 6144 blocks of 40 words starting at word 12, a 13-bit block number and a 55-cycle latency window.

Top module: `fm_rd_seq`

## Requirements
- R1: While `rst_n` is low, `rd_addr` is 0, `rd_strobe` is 0, `q_drive` is 0, and `blk_err` and `proto_err` are both 0.
- R2: A reset request is taken on the first edge at or after the rising edge of `rd_rst_req` on which `rd_en` is high. On that edge the pointer becomes 0 and `rd_strobe` stays low. If `rd_en` is low when the request rises, the request waits for the first edge with `rd_en` high. The next edge with `rd_en` high reads address 0.
- R3: In normal mode, an edge with `rd_en` high raises `rd_strobe` and puts the current pointer on `rd_addr`, then advances the pointer. An edge with `rd_en` low leaves the pointer and `rd_addr` unchanged and drops `rd_strobe`.
- R4: The pointer value after the last word (BASE_OFS + NUM_BLOCKS·BLOCK_WORDS − 1, by default 245771) is BASE_OFS (by default 12). Addresses below BASE_OFS occur only after a reset to zero.
- R5: In normal mode, `q_drive` after an edge equals `out_en` sampled at that edge, whether or not the pointer moved.
- R6: Block entry happens only under one pattern. Counting the reset edge as edge 1, `out_en` must be low with `rd_en` high on edges 1 and 2, and `out_en` must be high with `rd_en` low on edges 3 and 4. At the first edge that breaks this pattern the block behaves as in normal mode, so the reset was a reset to zero.
- R7: From edge 4 of a confirmed entry until the edge that starts reading, `q_drive` is 0 whatever `out_en` is.
- R8: On edges 5 to 4+BLK_W the block number is shifted in from `out_en`, most significant bit first. During this time the pointer does not advance and `rd_strobe` stays low.
- R9: A block number of NUM_BLOCKS or more (by default above 6143) sets `blk_err` on the last shift edge. While the error is set, `rd_strobe` and `q_drive` stay 0. The next accepted reset request clears `blk_err`.
- R10: After a valid number, the next LAT_CYCLES edges (by default 55) ignore `rd_en` and `out_en`. The first later edge with both high reads address BASE_OFS + BLOCK_WORDS·n and sets `q_drive`. Sequential reading continues from there.
- R11: A rising `rd_rst_req` during the shift or latency phases is ignored, and the sequence continues unchanged. It sets `proto_err`, which stays set until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_rst_req | input | 1 | Read reset request, acted on at its rising edge |
| rd_en | input | 1 | Read enable: advances the pointer |
| out_en | input | 1 | Output enable; serial block number during entry |
| rd_addr | output | ADDR_W | Address read at the last strobe |
| rd_strobe | output | 1 | A word was read at `rd_addr` this cycle |
| q_drive | output | 1 | Data pins driven (1) or high impedance (0) |
| blk_err | output | 1 | Out-of-range block number received |
| proto_err | output | 1 | Reset request refused during entry (sticky) |

## Verification
The assertions watch several rules on every cycle. A reset edge zeroes the pointer without a strobe. Enabled normal-mode edges read the old pointer, and disabled ones hold it. The registered enable follows its input in normal mode and stays low in every entry phase and in lockout. The start edge both strobes and drives, and the protocol flag never clears by itself. Only the bench scenarios can show which block number the serial bits build and whether the first read lands on the right block base. They also show the exact edge at which the latency window closes, the wrap point, and that a refused request leaves the entry unchanged.

// File: rtl/fm_rd_pkg.sv
package fm_rd_pkg;

  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_CHK   = 3'd1,
    PH_SHIFT = 3'd2,
    PH_LAT   = 3'd3,
    PH_RDY   = 3'd4,
    PH_LOCK  = 3'd5
  } rd_phase_e;

  // Next sequential pointer value; the top address folds back to the block area base.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned pmax, int unsigned base_ofs);
    return (p == pmax) ? base_ofs : p + 1;
  endfunction

  // First word of block n.
  function automatic int unsigned blk_base(int unsigned n, int unsigned base_ofs, int unsigned words);
    return base_ofs + n * words;
  endfunction

endpackage

// File: rtl/fm_rd_req_edge.sv
module fm_rd_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic rd_en_i,
  input  logic block_i,
  output logic fire_o,
  output logic viol_o
);

  logic req_q;
  logic pend_q;
  logic rise;

  assign rise   = req_i & ~req_q;
  assign fire_o = (rise | pend_q) & rd_en_i & ~block_i;
  assign viol_o = rise & block_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (fire_o)
        pend_q <= 1'b0;
      else if (rise && !block_i)
        pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fm_rd_entry_fsm.sv
module fm_rd_entry_fsm #(
  parameter int BLK_W      = 13,
  parameter int NUM_BLOCKS = 6144,
  parameter int LAT_CYCLES = 55
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire_i,
  input  logic                  viol_i,
  input  logic                  rd_en_i,
  input  logic                  out_en_i,
  output fm_rd_pkg::rd_phase_e  phase_o,
  output logic                  seq_mode_o,
  output logic                  block_o,
  output logic                  ld_o,
  output logic [BLK_W-1:0]      blk_o,
  output logic                  go_o,
  output logic                  drive_o,
  output logic                  blk_err_o,
  output logic                  proto_err_o
);
  import fm_rd_pkg::*;

  localparam int CNT_MAX = (BLK_W > LAT_CYCLES) ? BLK_W : LAT_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  rd_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] sr_q;
  logic [BLK_W-1:0] shift_full;
  logic             last_bit;
  logic             in_range;
  logic             chk_cond;
  logic             lat_done;

  assign shift_full = {sr_q[BLK_W-2:0], out_en_i};
  assign last_bit   = (phase_q == PH_SHIFT) && (cnt_q == CNT_W'(BLK_W - 1));
  assign in_range   = 32'(shift_full) < 32'(NUM_BLOCKS);
  assign lat_done   = (cnt_q == CNT_W'(LAT_CYCLES - 1));
  assign chk_cond   = (cnt_q == CNT_W'(1)) ? (~out_en_i & rd_en_i) : (out_en_i & ~rd_en_i);

  assign phase_o    = phase_q;
  assign blk_o      = shift_full;
  assign ld_o       = last_bit & in_range;
  assign go_o       = (phase_q == PH_RDY) & rd_en_i & out_en_i & ~fire_i;
  assign seq_mode_o = ((phase_q == PH_RUN) || (phase_q == PH_CHK)) && !fire_i;
  assign block_o    = (phase_q == PH_SHIFT) || (phase_q == PH_LAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_RUN;
      cnt_q       <= '0;
      sr_q        <= '0;
      drive_o     <= 1'b0;
      blk_err_o   <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      if (viol_i)
        proto_err_o <= 1'b1;
      if (fire_i) begin
        phase_q   <= out_en_i ? PH_RUN : PH_CHK;
        cnt_q     <= CNT_W'(1);
        drive_o   <= out_en_i;
        blk_err_o <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_RUN: drive_o <= out_en_i;
          PH_CHK: begin
            if (!chk_cond) begin
              phase_q <= PH_RUN;
              drive_o <= out_en_i;
            end else if (cnt_q == CNT_W'(3)) begin
              phase_q <= PH_SHIFT;
              cnt_q   <= '0;
              drive_o <= 1'b0;
            end else begin
              cnt_q   <= cnt_q + CNT_W'(1);
              drive_o <= out_en_i;
            end
          end
          PH_SHIFT: begin
            sr_q    <= shift_full;
            drive_o <= 1'b0;
            if (last_bit) begin
              cnt_q <= '0;
              if (in_range) begin
                phase_q <= PH_LAT;
              end else begin
                phase_q   <= PH_LOCK;
                blk_err_o <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_LAT: begin
            drive_o <= 1'b0;
            if (lat_done) begin
              phase_q <= PH_RDY;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_RDY: begin
            if (go_o) begin
              phase_q <= PH_RUN;
              drive_o <= 1'b1;
            end else begin
              drive_o <= 1'b0;
            end
          end
          default: drive_o <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/fm_rd_ptr_unit.sv
module fm_rd_ptr_unit #(
  parameter int ADDR_W      = 18,
  parameter int PTR_MAX     = 245771,
  parameter int BASE_OFS    = 12,
  parameter int BLOCK_WORDS = 40,
  parameter int BLK_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              ld_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              strobe_o
);
  import fm_rd_pkg::*;

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_nxt;
  logic [ADDR_W-1:0] base_addr;

  assign ptr_nxt   = ADDR_W'(ptr_step(32'(ptr_q), PTR_MAX, BASE_OFS));
  assign base_addr = ADDR_W'(blk_base(32'(blk_i), BASE_OFS, BLOCK_WORDS));
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      addr_o   <= '0;
      strobe_o <= 1'b0;
    end else if (fire_i) begin
      ptr_q    <= '0;
      strobe_o <= 1'b0;
    end else if (ld_i) begin
      ptr_q    <= base_addr;
      strobe_o <= 1'b0;
    end else if (adv_i) begin
      addr_o   <= ptr_q;
      ptr_q    <= ptr_nxt;
      strobe_o <= 1'b1;
    end else begin
      strobe_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fm_rd_seq.sv
module fm_rd_seq #(
  parameter int BLK_W       = 13,
  parameter int NUM_BLOCKS  = 6144,
  parameter int BLOCK_WORDS = 40,
  parameter int BASE_OFS    = 12,
  parameter int LAT_CYCLES  = 55,
  localparam int PTR_MAX    = BASE_OFS + NUM_BLOCKS * BLOCK_WORDS - 1,
  localparam int ADDR_W     = $clog2(PTR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_rst_req,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_strobe,
  output logic              q_drive,
  output logic              blk_err,
  output logic              proto_err
);
  import fm_rd_pkg::*;

  // Internal events, named so the bound checker can observe them.
  logic              fire_w;
  logic              viol_w;
  logic              block_w;
  logic              seq_mode_w;
  logic              ld_w;
  logic              go_w;
  logic              adv_w;
  logic              hiz_phase_w;
  logic              run_phase_w;
  logic [BLK_W-1:0]  blk_w;
  logic [ADDR_W-1:0] ptr_w;
  rd_phase_e         phase_w;

  fm_rd_req_edge u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (rd_rst_req),
    .rd_en_i (rd_en),
    .block_i (block_w),
    .fire_o  (fire_w),
    .viol_o  (viol_w)
  );

  fm_rd_entry_fsm #(
    .BLK_W      (BLK_W),
    .NUM_BLOCKS (NUM_BLOCKS),
    .LAT_CYCLES (LAT_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire_w),
    .viol_i      (viol_w),
    .rd_en_i     (rd_en),
    .out_en_i    (out_en),
    .phase_o     (phase_w),
    .seq_mode_o  (seq_mode_w),
    .block_o     (block_w),
    .ld_o        (ld_w),
    .blk_o       (blk_w),
    .go_o        (go_w),
    .drive_o     (q_drive),
    .blk_err_o   (blk_err),
    .proto_err_o (proto_err)
  );

  assign adv_w       = (seq_mode_w & rd_en) | go_w;
  assign hiz_phase_w = (phase_w == PH_SHIFT) || (phase_w == PH_LAT) ||
                       (phase_w == PH_RDY)   || (phase_w == PH_LOCK);
  assign run_phase_w = (phase_w == PH_RUN);

  fm_rd_ptr_unit #(
    .ADDR_W      (ADDR_W),
    .PTR_MAX     (PTR_MAX),
    .BASE_OFS    (BASE_OFS),
    .BLOCK_WORDS (BLOCK_WORDS),
    .BLK_W       (BLK_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire_w),
    .ld_i     (ld_w),
    .blk_i    (blk_w),
    .adv_i    (adv_w),
    .ptr_o    (ptr_w),
    .addr_o   (rd_addr),
    .strobe_o (rd_strobe)
  );

endmodule

// File: rtl/fm_rd_seq_chk.sv
module fm_rd_seq_chk #(
  parameter int ADDR_W  = 18,
  parameter int PTR_MAX = 245771
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              out_en,
  input logic              fire,
  input logic              seq_mode,
  input logic              go,
  input logic              hiz_phase,
  input logic              run_phase,
  input logic [ADDR_W-1:0] ptr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_strobe,
  input logic              q_drive,
  input logic              blk_err,
  input logic              proto_err
);

  a_r2_zero_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ptr == '0 && !rd_strobe));

  a_r3_reads_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && rd_en) |=> (rd_strobe && rd_addr == $past(ptr)));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !rd_en) |=> (!rd_strobe && $stable(ptr) && $stable(rd_addr)));

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (32'(rd_addr) <= 32'(PTR_MAX)));

  a_r5_drive_follows: assert property (@(posedge clk) disable iff (!rst_n)
    run_phase |=> (q_drive == $past(out_en)));

  a_r7_hiz_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_phase |-> !q_drive);

  a_r9_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |-> (!rd_strobe && !q_drive));

  a_r10_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (rd_strobe && q_drive));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind fm_rd_seq fm_rd_seq_chk #(
  .ADDR_W  (ADDR_W),
  .PTR_MAX (PTR_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .out_en    (out_en),
  .fire      (fire_w),
  .seq_mode  (seq_mode_w),
  .go        (go_w),
  .hiz_phase (hiz_phase_w),
  .run_phase (run_phase_w),
  .ptr       (ptr_w),
  .rd_addr   (rd_addr),
  .rd_strobe (rd_strobe),
  .q_drive   (q_drive),
  .blk_err   (blk_err),
  .proto_err (proto_err)
);

// File: tb/fm_rd_seq_bench.sv
module fm_rd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW   = 4;
  localparam int NB   = 12;
  localparam int WD   = 5;
  localparam int BOFS = 3;
  localparam int LAT  = 6;
  localparam int PMAX = BOFS + NB * WD - 1;
  localparam int AW   = $clog2(PMAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          re = 1'b0;
  logic          oe = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_strobe;
  logic          q_drive;
  logic          blk_err;
  logic          proto_err;

  int n_chk = 0;
  int n_err = 0;
  int cur   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fm_rd_seq #(
    .BLK_W(BW), .NUM_BLOCKS(NB), .BLOCK_WORDS(WD), .BASE_OFS(BOFS), .LAT_CYCLES(LAT)
  ) u_fm_rd_seq (
    .clk(clk), .rst_n(rst_n), .rd_rst_req(req), .rd_en(re), .out_en(oe),
    .rd_addr(rd_addr), .rd_strobe(rd_strobe), .q_drive(q_drive),
    .blk_err(blk_err), .proto_err(proto_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic o);
    @(negedge clk);
    req = r; re = e; oe = o;
    @(posedge clk);
    #1;
  endtask

  // Expected read at the model pointer, then advance the model.
  task automatic expect_read(input string tag);
    check(tag, {31'd0, rd_strobe}, 1);
    check(tag, int'(rd_addr), cur);
    cur = (cur >= PMAX) ? BOFS : cur + 1;
  endtask

  task automatic entry(input int n, input bit viol);
    step(0, 0, 0); step(0, 0, 0);
    step(1, 1, 0);
    check("R9 err cleared by reset", {31'd0, blk_err}, 0);
    check("R2 no strobe on reset edge", {31'd0, rd_strobe}, 0);
    cur = 0;
    step(0, 1, 0);
    expect_read("R6 edge2 reads");
    step(0, 0, 1);
    check("R6 edge3 drive follows", {31'd0, q_drive}, 1);
    step(0, 0, 1);
    check("R7 edge4 hiz", {31'd0, q_drive}, 0);
    for (int b = BW - 1; b >= 0; b--) begin
      step(viol && (b == 1), 0, n[b]);
      check("R7 hiz while shifting", {31'd0, q_drive}, 0);
      check("R8 no strobe while shifting", {31'd0, rd_strobe}, 0);
    end
    if (n >= NB) begin
      check("R9 error raised", {31'd0, blk_err}, 1);
      for (int k = 0; k < 3; k++) begin
        step(0, 1, 1);
        check("R9 locked no strobe", {31'd0, rd_strobe}, 0);
        check("R9 locked hiz", {31'd0, q_drive}, 0);
      end
      return;
    end
    check("R9 no error", {31'd0, blk_err}, 0);
    for (int k = 0; k < LAT - 1; k++) begin
      step(0, 0, 0);
      check("R10 hiz in latency", {31'd0, q_drive}, 0);
    end
    step(0, 1, 1);
    check("R10 last latency edge ignored", {31'd0, rd_strobe}, 0);
    check("R10 last latency edge hiz", {31'd0, q_drive}, 0);
    cur = BOFS + WD * n;
    step(0, 1, 1);
    expect_read("R10 first read at block base");
    check("R10 drive on start", {31'd0, q_drive}, 1);
    for (int k = 0; k < WD + 1; k++) begin
      step(0, 1, 1);
      expect_read("R8 sequential after entry");
    end
    if (viol) check("R11 refused request flagged", {31'd0, proto_err}, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr", int'(rd_addr), 0);
    check("R1 strobe", {31'd0, rd_strobe}, 0);
    check("R1 drive", {31'd0, q_drive}, 0);
    check("R1 blk_err", {31'd0, blk_err}, 0);
    check("R1 proto_err", {31'd0, proto_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    // Plain reset and a long sequential run across the wrap point.
    step(0, 0, 0);
    step(1, 1, 1);
    check("R2 reset edge no strobe", {31'd0, rd_strobe}, 0);
    check("R5 drive on reset edge", {31'd0, q_drive}, 1);
    cur = 0;
    for (int k = 0; k < 2 * PMAX + 6; k++) begin
      bit wrap;
      wrap = (cur == PMAX);
      step(0, 1, 1);
      expect_read(wrap ? "R4 wrap to base" : "R3 sequential");
    end

    // Hold and output gating.
    begin
      int last;
      last = int'(rd_addr);
      step(0, 0, 1);
      check("R3 hold no strobe", {31'd0, rd_strobe}, 0);
      check("R3 hold addr", int'(rd_addr), last);
      check("R5 drive high", {31'd0, q_drive}, 1);
      step(0, 1, 0);
      expect_read("R5 advance while hiz");
      check("R5 drive low", {31'd0, q_drive}, 0);
    end

    // Pending reset: request rises while reads are disabled.
    step(0, 0, 0);
    step(1, 0, 1);
    check("R2 pending no strobe", {31'd0, rd_strobe}, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    check("R2 pending taken no strobe", {31'd0, rd_strobe}, 0);
    cur = 0;
    step(0, 1, 1);
    expect_read("R2 pending reads zero");

    // Qualification broken on edge 3.
    step(0, 0, 0); step(0, 0, 0);
    step(1, 1, 0);
    cur = 0;
    step(0, 1, 0);
    expect_read("R6 edge2");
    step(0, 1, 1);
    expect_read("R6 broken edge3 reads");
    check("R6 broken edge3 drives", {31'd0, q_drive}, 1);

    // Qualification broken on edge 1.
    step(0, 0, 0); step(0, 0, 0);
    step(1, 1, 1);
    check("R6 edge1 oe high drives", {31'd0, q_drive}, 1);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 1);
      check("R6 plain reset keeps oe control", {31'd0, q_drive}, 1);
    end

    // Every block number of the small configuration, valid and invalid.
    for (int n = 0; n < (1 << BW); n++) entry(n, 1'b0);
    check("R11 no flag without violation", {31'd0, proto_err}, 0);

    entry(5, 1'b1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule